// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM Port Control

A clocked dual-port word memory with two identical, independent ports, left and right. Each port has seven controls: a split chip enable (one active-low pin, one active-high pin), a read/write strobe, an output enable, two active-low byte enables and a semaphore select. The block turns these controls into per-lane write strobes and per-lane read enables. It returns registered read data with a separate output-enable bit for each byte lane, and these bits stand in for tri-state drivers. It also reports per-port power-down and lane-deselect status, and a same-address write collision between the two ports.

The semaphore flags are held in a companion block. This block only decodes when a port is addressing that space, and while a port does so its memory path is inhibited. The memory depth is set by `ADDR_W`. A full-size instance uses 16, which gives 64K words of two 8-bit lanes. The default is smaller to keep elaboration light.

Top module: `dpram_ctrl`

## Requirements
- R1: A port is selected only when its `ce0_ni` is 0 and its `ce1_i` is 1. In every other combination `pdown_o` is 1 and the port neither writes nor drives read data.
- R2: On a selected port with `rw_i`=0 and `sem_ni`=1, a rising clock edge writes bits 15..8 when `ub_ni`=0 and bits 7..0 when `lb_ni`=0. A lane whose enable is 1 keeps its stored contents.
- R3: On a selected port with `rw_i`=1, `oe_ni`=0 and `sem_ni`=1, the controls sampled at a clock edge set `data_oe_o` after that edge. Bit 1 is set for the upper lane when `ub_ni`=0, and bit 0 for the lower lane when `lb_ni`=0. Each enabled lane of `rdata_o` carries the stored data, and each disabled lane reads as zero.
- R4: An edge sampled with `oe_ni`=1 clears both `data_oe_o` bits, whatever the other controls are.
- R5: `lanes_off_o` is 1 whenever `ub_ni` and `lb_ni` are both 1. In that state nothing is written and no lane is driven.
- R6: While `sem_ni`=0, the port's memory path is inhibited: no write takes place and `data_oe_o` becomes 0.
- R7: `sem_acc_o` is 1 when `sem_ni`=0 and the port is either deselected or has both byte enables at 1. `sem_we_o` is `sem_acc_o` qualified by `rw_i`=0. A semaphore select with a byte enable low on a selected port raises neither signal.
- R8: When both ports write the same address in one cycle, `contention_o` is 1 in that cycle. On every lane that the right port writes, the right port's data is stored. A lane that only the left port writes takes the left port's data.
- R9: A read returns the contents held before a write that lands at the same edge on the same address.
- R10: While `rst_ni` is 0, `data_oe_o` and `rdata_o` are 0 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce0_ni | input | 1 | Left chip enable, active low half |
| l_ce1_i | input | 1 | Left chip enable, active high half |
| l_rw_i | input | 1 | Left read (1) / write (0) |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_ub_ni | input | 1 | Left upper byte enable, active low |
| l_lb_ni | input | 1 | Left lower byte enable, active low |
| l_sem_ni | input | 1 | Left semaphore select, active low |
| l_addr_i | input | ADDR_W | Left word address |
| l_wdata_i | input | 16 | Left write data |
| l_rdata_o | output | 16 | Left read data, zero on undriven lanes |
| l_data_oe_o | output | 2 | Left lane drive enables, bit 1 upper |
| l_pdown_o | output | 1 | Left port deselected / powered down |
| l_lanes_off_o | output | 1 | Left both byte lanes deselected |
| l_sem_acc_o | output | 1 | Left semaphore space access |
| l_sem_we_o | output | 1 | Left semaphore write |
| r_ce0_ni | input | 1 | Right chip enable, active low half |
| r_ce1_i | input | 1 | Right chip enable, active high half |
| r_rw_i | input | 1 | Right read (1) / write (0) |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_ub_ni | input | 1 | Right upper byte enable, active low |
| r_lb_ni | input | 1 | Right lower byte enable, active low |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_addr_i | input | ADDR_W | Right word address |
| r_wdata_i | input | 16 | Right write data |
| r_rdata_o | output | 16 | Right read data, zero on undriven lanes |
| r_data_oe_o | output | 2 | Right lane drive enables, bit 1 upper |
| r_pdown_o | output | 1 | Right port deselected / powered down |
| r_lanes_off_o | output | 1 | Right both byte lanes deselected |
| r_sem_acc_o | output | 1 | Right semaphore space access |
| r_sem_we_o | output | 1 | Right semaphore write |
| contention_o | output | 1 | Both ports writing the same address this cycle |

## Verification
A stale or wrong lane-enable register shows on the very next cycle as a `data_oe_o` bit that disagrees with the controls sampled one edge earlier. Because disabled lanes must read as zero, it also shows as a lane of `rdata_o` with the wrong value. A corrupted stored word, a lane written when it should have been masked, or the wrong winner of a collision stays hidden until that address is read back. It then appears one cycle after the read is issued, so the bench reads back every word it has written, partially written or collided on. The decode outputs are combinational and are compared in the same cycle as their inputs.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int N_LANES = 2;  // lane 1 = upper byte, lane 0 = lower byte
  localparam int N_PORTS = 2;  // port 0 = left, port 1 = right

  typedef struct packed {
    logic ce0_n;
    logic ce1;
    logic rw;
    logic oe_n;
    logic ub_n;
    logic lb_n;
    logic sem_n;
  } port_ctrl_t;

  typedef struct packed {
    logic               pdown;
    logic               lanes_off;
    logic [N_LANES-1:0] we;
    logic [N_LANES-1:0] re;
    logic               sem_acc;
    logic               sem_we;
  } port_dec_t;
endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec
  import dpram_pkg::*;
(
  input  port_ctrl_t ctrl_i,
  output port_dec_t  dec_o
);
  logic               sel;
  logic               mem_path;
  logic [N_LANES-1:0] lane_en;

  assign sel      = !ctrl_i.ce0_n && ctrl_i.ce1;
  assign lane_en  = {!ctrl_i.ub_n, !ctrl_i.lb_n};
  // semaphore select steals the port from the array
  assign mem_path = sel && ctrl_i.sem_n;

  always_comb begin
    dec_o           = '0;
    dec_o.pdown     = !sel;
    dec_o.lanes_off = ctrl_i.ub_n && ctrl_i.lb_n;
    dec_o.we        = (mem_path && !ctrl_i.rw) ? lane_en : '0;
    dec_o.re        = (mem_path && ctrl_i.rw && !ctrl_i.oe_n) ? lane_en : '0;
    dec_o.sem_acc   = !ctrl_i.sem_n && (!sel || (ctrl_i.ub_n && ctrl_i.lb_n));
    dec_o.sem_we    = dec_o.sem_acc && !ctrl_i.rw;
  end
endmodule

// File: rtl/dpram_lane_mem.sv
module dpram_lane_mem #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [LANE_W-1:0] l_wd_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [LANE_W-1:0] r_wd_i,
  output logic [LANE_W-1:0] l_rd_o,
  output logic [LANE_W-1:0] r_rd_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];
  logic              l_blocked;

  // right port owns the lane on a same-address collision
  assign l_blocked = r_we_i && (l_addr_i == r_addr_i);

  always_ff @(posedge clk_i) begin
    l_rd_o <= mem_q[l_addr_i];
    r_rd_o <= mem_q[r_addr_i];
    if (l_we_i && !l_blocked) mem_q[l_addr_i] <= l_wd_i;
    if (r_we_i)               mem_q[r_addr_i] <= r_wd_i;
  end
endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
  import dpram_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DATA_W = N_LANES * LANE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LANES-1:0] re_i,
  input  logic [DATA_W-1:0]  raw_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [N_LANES-1:0] data_oe_o
);
  logic [N_LANES-1:0] oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= '0;
    else         oe_q <= re_i;
  end

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    assign rdata_o[i*LANE_W +: LANE_W] = oe_q[i] ? raw_i[i*LANE_W +: LANE_W] : '0;
  end

  assign data_oe_o = oe_q;
endmodule

// File: rtl/dpram_ctrl.sv
module dpram_ctrl
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DATA_W = N_LANES * LANE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               l_ce0_ni,
  input  logic               l_ce1_i,
  input  logic               l_rw_i,
  input  logic               l_oe_ni,
  input  logic               l_ub_ni,
  input  logic               l_lb_ni,
  input  logic               l_sem_ni,
  input  logic [ADDR_W-1:0]  l_addr_i,
  input  logic [DATA_W-1:0]  l_wdata_i,
  output logic [DATA_W-1:0]  l_rdata_o,
  output logic [N_LANES-1:0] l_data_oe_o,
  output logic               l_pdown_o,
  output logic               l_lanes_off_o,
  output logic               l_sem_acc_o,
  output logic               l_sem_we_o,
  input  logic               r_ce0_ni,
  input  logic               r_ce1_i,
  input  logic               r_rw_i,
  input  logic               r_oe_ni,
  input  logic               r_ub_ni,
  input  logic               r_lb_ni,
  input  logic               r_sem_ni,
  input  logic [ADDR_W-1:0]  r_addr_i,
  input  logic [DATA_W-1:0]  r_wdata_i,
  output logic [DATA_W-1:0]  r_rdata_o,
  output logic [N_LANES-1:0] r_data_oe_o,
  output logic               r_pdown_o,
  output logic               r_lanes_off_o,
  output logic               r_sem_acc_o,
  output logic               r_sem_we_o,
  output logic               contention_o
);
  port_ctrl_t          ctrl  [N_PORTS];
  port_dec_t           dec   [N_PORTS];
  logic [ADDR_W-1:0]   addr  [N_PORTS];
  logic [DATA_W-1:0]   wdata [N_PORTS];
  logic [DATA_W-1:0]   raw   [N_PORTS];
  logic [DATA_W-1:0]   rdata [N_PORTS];
  logic [N_LANES-1:0]  oe    [N_PORTS];

  assign ctrl[0]  = '{ce0_n: l_ce0_ni, ce1: l_ce1_i, rw: l_rw_i, oe_n: l_oe_ni,
                      ub_n: l_ub_ni, lb_n: l_lb_ni, sem_n: l_sem_ni};
  assign ctrl[1]  = '{ce0_n: r_ce0_ni, ce1: r_ce1_i, rw: r_rw_i, oe_n: r_oe_ni,
                      ub_n: r_ub_ni, lb_n: r_lb_ni, sem_n: r_sem_ni};
  assign addr[0]  = l_addr_i;
  assign addr[1]  = r_addr_i;
  assign wdata[0] = l_wdata_i;
  assign wdata[1] = r_wdata_i;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    dpram_port_dec u_dec (
      .ctrl_i (ctrl[p]),
      .dec_o  (dec[p])
    );

    dpram_port_out #(.LANE_W(LANE_W)) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .re_i      (dec[p].re),
      .raw_i     (raw[p]),
      .rdata_o   (rdata[p]),
      .data_oe_o (oe[p])
    );
  end

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    dpram_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk_i    (clk_i),
      .l_we_i   (dec[0].we[i]),
      .l_addr_i (addr[0]),
      .l_wd_i   (wdata[0][i*LANE_W +: LANE_W]),
      .r_we_i   (dec[1].we[i]),
      .r_addr_i (addr[1]),
      .r_wd_i   (wdata[1][i*LANE_W +: LANE_W]),
      .l_rd_o   (raw[0][i*LANE_W +: LANE_W]),
      .r_rd_o   (raw[1][i*LANE_W +: LANE_W])
    );
  end

  assign contention_o  = (|dec[0].we) && (|dec[1].we) && (addr[0] == addr[1]);

  assign l_rdata_o     = rdata[0];
  assign l_data_oe_o   = oe[0];
  assign l_pdown_o     = dec[0].pdown;
  assign l_lanes_off_o = dec[0].lanes_off;
  assign l_sem_acc_o   = dec[0].sem_acc;
  assign l_sem_we_o    = dec[0].sem_we;
  assign r_rdata_o     = rdata[1];
  assign r_data_oe_o   = oe[1];
  assign r_pdown_o     = dec[1].pdown;
  assign r_lanes_off_o = dec[1].lanes_off;
  assign r_sem_acc_o   = dec[1].sem_acc;
  assign r_sem_we_o    = dec[1].sem_we;
endmodule

// File: rtl/dpram_ctrl_chk.sv
module dpram_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_rw_i,
  input logic              l_oe_ni,
  input logic              l_ub_ni,
  input logic              l_sem_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic [1:0]        l_data_oe_o,
  input logic              l_pdown_o,
  input logic              l_lanes_off_o,
  input logic              l_sem_acc_o,
  input logic              l_sem_we_o,
  input logic              r_rw_i,
  input logic              r_oe_ni,
  input logic              r_sem_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic [1:0]        r_data_oe_o,
  input logic              r_pdown_o,
  input logic              r_sem_acc_o,
  input logic              r_sem_we_o,
  input logic              contention_o
);
  p_pdown_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(l_pdown_o) |-> l_data_oe_o == 2'b00);
  p_pdown_quiet_r_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(r_pdown_o) |-> r_data_oe_o == 2'b00);
  p_upper_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(l_ub_ni) |-> !l_data_oe_o[1]);
  p_oe_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(l_oe_ni) |-> l_data_oe_o == 2'b00);
  p_oe_off_r_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(r_oe_ni) |-> r_data_oe_o == 2'b00);
  p_lanes_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(l_lanes_off_o) |-> l_data_oe_o == 2'b00);
  p_sem_inhibit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!l_sem_ni) |-> l_data_oe_o == 2'b00);
  p_sem_inhibit_r_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!r_sem_ni) |-> r_data_oe_o == 2'b00);
  p_sem_we_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_sem_we_o |-> l_sem_acc_o && !l_rw_i && !l_sem_ni);
  p_sem_we_r_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_sem_we_o |-> r_sem_acc_o && !r_rw_i && !r_sem_ni);
  p_contention_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    contention_o |-> (l_addr_i == r_addr_i) && !l_rw_i && !r_rw_i && !l_pdown_o && !r_pdown_o);
endmodule

bind dpram_ctrl dpram_ctrl_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/dpram_ctrl_test.sv
module dpram_ctrl_test;
  localparam int AW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          ce0_n [2];
  logic          ce1   [2];
  logic          rw    [2];
  logic          oe_n  [2];
  logic          ub_n  [2];
  logic          lb_n  [2];
  logic          sem_n [2];
  logic [AW-1:0] addr  [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [1:0]    doe   [2];
  logic          pdown [2];
  logic          loff  [2];
  logic          sacc  [2];
  logic          swe   [2];
  logic          contention;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] mem_m [int];
  logic [1:0]    kn_m  [int];
  logic [1:0]    exp_oe [2];
  logic [1:0]    exp_kn [2];
  logic [DW-1:0] exp_rd [2];

  dpram_ctrl #(.ADDR_W(AW), .LANE_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce0_ni(ce0_n[0]), .l_ce1_i(ce1[0]), .l_rw_i(rw[0]), .l_oe_ni(oe_n[0]),
    .l_ub_ni(ub_n[0]), .l_lb_ni(lb_n[0]), .l_sem_ni(sem_n[0]),
    .l_addr_i(addr[0]), .l_wdata_i(wdata[0]), .l_rdata_o(rdata[0]),
    .l_data_oe_o(doe[0]), .l_pdown_o(pdown[0]), .l_lanes_off_o(loff[0]),
    .l_sem_acc_o(sacc[0]), .l_sem_we_o(swe[0]),
    .r_ce0_ni(ce0_n[1]), .r_ce1_i(ce1[1]), .r_rw_i(rw[1]), .r_oe_ni(oe_n[1]),
    .r_ub_ni(ub_n[1]), .r_lb_ni(lb_n[1]), .r_sem_ni(sem_n[1]),
    .r_addr_i(addr[1]), .r_wdata_i(wdata[1]), .r_rdata_o(rdata[1]),
    .r_data_oe_o(doe[1]), .r_pdown_o(pdown[1]), .r_lanes_off_o(loff[1]),
    .r_sem_acc_o(sacc[1]), .r_sem_we_o(swe[1]),
    .contention_o(contention)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic idle(int p);
    ce0_n[p] = 1'b1; ce1[p] = 1'b0; rw[p] = 1'b1; oe_n[p] = 1'b1;
    ub_n[p] = 1'b1; lb_n[p] = 1'b1; sem_n[p] = 1'b1;
    addr[p] = '0; wdata[p] = '0;
  endtask

  task automatic wr(int p, int a, logic [DW-1:0] d, logic ub, logic lb);
    ce0_n[p] = 1'b0; ce1[p] = 1'b1; rw[p] = 1'b0; oe_n[p] = 1'b1;
    ub_n[p] = ub; lb_n[p] = lb; sem_n[p] = 1'b1;
    addr[p] = AW'(a); wdata[p] = d;
  endtask

  task automatic rd(int p, int a, logic ub, logic lb);
    ce0_n[p] = 1'b0; ce1[p] = 1'b1; rw[p] = 1'b1; oe_n[p] = 1'b0;
    ub_n[p] = ub; lb_n[p] = lb; sem_n[p] = 1'b1;
    addr[p] = AW'(a); wdata[p] = '0;
  endtask

  // one clock of reference model; inputs already set at a falling edge
  task automatic cyc(string tag);
    logic [1:0] wl [2];
    logic [1:0] rl [2];
    logic [1:0] be;
    logic sel;
    logic [DW-1:0] w;
    #1;
    for (int p = 0; p < 2; p++) begin
      sel = !ce0_n[p] && ce1[p];
      be = {!ub_n[p], !lb_n[p]};
      wl[p] = (sel && sem_n[p] && !rw[p]) ? be : 2'b00;
      rl[p] = (sel && sem_n[p] && rw[p] && !oe_n[p]) ? be : 2'b00;
      chk(tag, "pdown", pdown[p], !sel);
      chk(tag, "lanes_off", loff[p], ub_n[p] && lb_n[p]);
      chk(tag, "sem_acc", sacc[p], !sem_n[p] && (!sel || (ub_n[p] && lb_n[p])));
      chk(tag, "sem_we", swe[p], !sem_n[p] && (!sel || (ub_n[p] && lb_n[p])) && !rw[p]);
    end
    chk(tag, "contention", contention, (|wl[0]) && (|wl[1]) && (addr[0] == addr[1]));
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      exp_oe[p] = rl[p];
      exp_kn[p] = 2'b00;
      exp_rd[p] = '0;
      if (kn_m.exists(int'(addr[p]))) begin
        exp_kn[p] = kn_m[int'(addr[p])] & rl[p];
        exp_rd[p] = mem_m[int'(addr[p])];
      end
    end
    for (int p = 0; p < 2; p++) begin  // right applied last: wins its lanes
      for (int i = 0; i < 2; i++) begin
        if (wl[p][i]) begin
          if (!kn_m.exists(int'(addr[p]))) begin
            mem_m[int'(addr[p])] = '0;
            kn_m[int'(addr[p])] = 2'b00;
          end
          w = mem_m[int'(addr[p])];
          w[i*8 +: 8] = wdata[p][i*8 +: 8];
          mem_m[int'(addr[p])] = w;
          kn_m[int'(addr[p])][i] = 1'b1;
        end
      end
    end
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(tag, "data_oe", doe[p], exp_oe[p]);
      for (int i = 0; i < 2; i++) begin
        if (!exp_oe[p][i])
          chk(tag, "undriven lane", rdata[p][i*8 +: 8], 8'h00);
        else if (exp_kn[p][i])
          chk(tag, "read lane", rdata[p][i*8 +: 8], exp_rd[p][i*8 +: 8]);
      end
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #200us;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    idle(0);
    idle(1);
    repeat (2) @(negedge clk);
    // R10: reset state
    for (int p = 0; p < 2; p++) begin
      chk("R10", "reset data_oe", doe[p], 2'b00);
      chk("R10", "reset rdata", rdata[p], 16'h0000);
    end
    rst_n = 1'b1;
    cyc("R10");

    // R2: fill words from both ports
    for (int a = 0; a < 8; a++) begin
      wr(0, a, 16'hA000 + 16'(a * 17), 1'b0, 1'b0);
      wr(1, a + 8, 16'hB000 + 16'(a * 33), 1'b0, 1'b0);
      cyc("R2");
    end
    // R3: full and single-lane reads
    for (int a = 0; a < 8; a++) begin
      rd(0, a, 1'b0, 1'b0);
      rd(1, a + 8, 1'b0, 1'b0);
      cyc("R3");
    end
    rd(0, 2, 1'b0, 1'b1);
    rd(1, 9, 1'b1, 1'b0);
    cyc("R3");
    rd(0, 10, 1'b1, 1'b0);
    rd(1, 3, 1'b0, 1'b1);
    cyc("R3");

    // R2: partial lane writes, then read back
    wr(0, 4, 16'h1234, 1'b0, 1'b1);
    wr(1, 12, 16'h5678, 1'b1, 1'b0);
    cyc("R2");
    rd(0, 4, 1'b0, 1'b0);
    rd(1, 12, 1'b0, 1'b0);
    cyc("R2");

    // R4: output enable high blocks drive
    rd(0, 5, 1'b0, 1'b0);
    oe_n[0] = 1'b1;
    rd(1, 5, 1'b0, 1'b0);
    cyc("R4");
    rw[0] = 1'b0;
    ub_n[0] = 1'b1;
    lb_n[0] = 1'b1;
    idle(1);
    cyc("R4");

    // R5: both byte enables high
    wr(0, 6, 16'hFFFF, 1'b1, 1'b1);
    rd(1, 6, 1'b1, 1'b1);
    cyc("R5");
    rd(0, 6, 1'b0, 1'b0);
    idle(1);
    cyc("R5");

    // R6: semaphore select inhibits the array
    wr(0, 7, 16'hDEAD, 1'b0, 1'b0);
    sem_n[0] = 1'b0;
    rd(1, 7, 1'b0, 1'b0);
    sem_n[1] = 1'b0;
    cyc("R6");
    rd(0, 7, 1'b0, 1'b0);
    idle(1);
    cyc("R6");

    // R7: semaphore access decode
    idle(0); sem_n[0] = 1'b0; oe_n[0] = 1'b0;
    idle(1); sem_n[1] = 1'b0; rw[1] = 1'b0;
    cyc("R7");
    rd(0, 1, 1'b1, 1'b1); sem_n[0] = 1'b0;
    wr(1, 2, 16'h0001, 1'b1, 1'b1); sem_n[1] = 1'b0;
    cyc("R7");
    rd(0, 1, 1'b0, 1'b1); sem_n[0] = 1'b0;
    wr(1, 2, 16'h0001, 1'b1, 1'b0); sem_n[1] = 1'b0;
    cyc("R7");
    idle(0);
    idle(1);
    cyc("R7");

    // R1: every deselecting chip-enable combination
    for (int k = 0; k < 3; k++) begin
      wr(0, 0, 16'h5A5A, 1'b0, 1'b0);
      ce0_n[0] = (k != 1);
      ce1[0]   = (k == 0);
      rd(1, 1, 1'b0, 1'b0);
      ce0_n[1] = (k != 1);
      ce1[1]   = (k == 0);
      cyc("R1");
    end
    rd(0, 0, 1'b0, 1'b0);
    rd(1, 1, 1'b0, 1'b0);
    cyc("R1");

    // R8: same-address writes
    wr(0, 20, 16'h1111, 1'b0, 1'b0);
    wr(1, 20, 16'h2222, 1'b0, 1'b0);
    cyc("R8");
    wr(0, 21, 16'hAAAA, 1'b0, 1'b0);
    wr(1, 21, 16'hBBBB, 1'b0, 1'b1);
    cyc("R8");
    wr(0, 22, 16'hC3C3, 1'b0, 1'b0);
    wr(1, 23, 16'h3C3C, 1'b0, 1'b0);
    cyc("R8");
    rd(0, 20, 1'b0, 1'b0);
    rd(1, 21, 1'b0, 1'b0);
    cyc("R8");
    rd(0, 22, 1'b0, 1'b0);
    rd(1, 23, 1'b0, 1'b0);
    cyc("R8");

    // R9: read before write at one edge
    rd(0, 3, 1'b0, 1'b0);
    wr(1, 3, 16'hCAFE, 1'b0, 1'b0);
    cyc("R9");
    rd(0, 3, 1'b0, 1'b0);
    idle(1);
    cyc("R9");

    // R10: reset clears output state asynchronously
    rd(0, 3, 1'b0, 1'b0);
    rd(1, 3, 1'b0, 1'b0);
    cyc("R10");
    rst_n = 1'b0;
    #2;
    for (int p = 0; p < 2; p++) begin
      chk("R10", "async reset data_oe", doe[p], 2'b00);
      chk("R10", "async reset rdata", rdata[p], 16'h0000);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule